// File: doc/BRIEF.md
# Capture, Compare and Pulse-Width Channel

This block is one timer channel that works in one of three ways. A 4-bit mode field picks the way. In capture modes it copies a 16-bit free-running timer into its value register when the input pin shows the selected edge, or after every 4th or 16th rising edge. In compare modes it checks the value register against the same timer. On a match it sets or clears its output pin, or raises only its flag, or sends out a one-cycle special event that can be used to restart the timer. In PWM mode it drives a pulse whose period comes from an 8-bit timer and its match pulse. The duty has 10 bits: the low value byte gives the upper eight and two control bits give the lowest two.

Software reaches the channel through a small byte-wide register port. The timers, their prescalers and their match logic stay outside the block and are fed in as plain values. The channel flag is sticky, so it stays set until software clears it. The capture pin goes through a synchronizer before its edges are found.

Top module: `ccp_unit`

## Requirements
- R1: After reset, all four registers read 0x00. The output pin, the flag and the event pulse are all low.
- R2: Mode codes 0000 to 0011 are off. In these modes pin edges capture nothing, timer matches do nothing, the value register keeps its content, and the pin and the flag stay low.
- R3: Mode 0101 copies the 16-bit timer into the value register on each rising edge of the capture pin. Mode 0100 does the same on each falling edge. Each capture sets the flag. An edge of the other polarity has no effect.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. The edges before that capture nothing and leave the flag alone.
- R5: Any change of the mode field clears the edge counter, so counting starts again from zero.
- R6: On entry to mode 1000 the pin is driven low, and a timer match drives it high. On entry to mode 1001 the pin is driven high, and a match drives it low. A match also sets the flag.
- R7: In mode 1010 a match sets the flag and the pin stays low.
- R8: In mode 1011 a match sets the flag and raises the event output for exactly one cycle, even if the timer keeps the matching value.
- R9: The flag is bit 0 of register 3. Once set, it stays set until software writes 0 to that bit. Writes to other registers leave it unchanged.
- R10: In modes 11xx the pin goes high at each period-match pulse if the buffered duty is not zero. It goes low once the count {period timer, 2-bit sub-count} reaches the duty {value low byte, control bits 5:4}. A duty of zero keeps the pin low.
- R11: The PWM duty is loaded only at a period-match pulse. A duty written in the middle of a period does not change the current period.
- R12: Register 0 holds the value low byte and register 1 the value high byte. Register 2 holds the mode in bits 3:0 and the extra duty bits in bits 5:4. Bits 7:6 of register 2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 value low, 1 value high, 2 control, 3 flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| tmr_wide | input | 16 | Free-running 16-bit timer value |
| tmr_period | input | 8 | 8-bit period timer value |
| tmr_sub | input | 2 | Sub-count that extends the period timer to 10 bits |
| period_hit | input | 1 | One-cycle pulse when the period timer wraps |
| cap_in | input | 1 | Capture pin, asynchronous |
| ccp_pin | output | 1 | Compare or PWM output |
| ccp_flag | output | 1 | Sticky channel interrupt flag |
| ccp_event | output | 1 | One-cycle special-event pulse |

## Verification
Suppose the edge counter kept a stale count across a mode change. The flag would then rise one to three edges too early, and the value register would show a timer value from the wrong edge, within four cycles of that edge. A wrong compare match history would show as a repeated event pulse in the very next cycle, or as a missing flag one cycle after the match. A duty register loaded at the wrong time would move the falling edge of the pin within the current period, one cycle after the count passes the old or the new duty.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;

  typedef enum logic [1:0] {
    SEL_OFF     = 2'd0,
    SEL_CAPTURE = 2'd1,
    SEL_COMPARE = 2'd2,
    SEL_PWM     = 2'd3
  } ccp_sel_e;

  localparam logic [3:0] M_CAP_FALL   = 4'b0100;
  localparam logic [3:0] M_CAP_RISE   = 4'b0101;
  localparam logic [3:0] M_CAP_RISE4  = 4'b0110;
  localparam logic [3:0] M_CAP_RISE16 = 4'b0111;
  localparam logic [3:0] M_CMP_SET    = 4'b1000;
  localparam logic [3:0] M_CMP_CLR    = 4'b1001;
  localparam logic [3:0] M_CMP_IRQ    = 4'b1010;
  localparam logic [3:0] M_CMP_EVT    = 4'b1011;

  function automatic ccp_sel_e decode_sel(input logic [3:0] mode);
    case (mode[3:2])
      2'b00:   return SEL_OFF;
      2'b01:   return SEL_CAPTURE;
      2'b10:   return SEL_COMPARE;
      default: return SEL_PWM;
    endcase
  endfunction

endpackage

// File: rtl/ccp_capture.sv
`timescale 1ns/1ps
module ccp_capture
  import ccp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       mode_chg,
  input  logic       cap_in,
  output logic       fire
);

  localparam logic [CNT_W-1:0] LIM_ONE = CNT_W'(0);
  localparam logic [CNT_W-1:0] LIM_4TH = CNT_W'(3);
  localparam logic [CNT_W-1:0] LIM_16TH = CNT_W'(15);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [CNT_W-1:0]       limit;
  logic                   lvl, rise, fall, edge_hit, active;

  assign lvl  = sync_q[SYNC_STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    case (mode)
      M_CAP_RISE4:  limit = LIM_4TH;
      M_CAP_RISE16: limit = LIM_16TH;
      default:      limit = LIM_ONE;
    endcase
  end

  assign active   = (decode_sel(mode) == SEL_CAPTURE) && !mode_chg;
  assign edge_hit = (mode == M_CAP_FALL) ? fall : rise;
  assign fire     = active && edge_hit && (cnt_q == limit);

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], cap_in};
    prev_d = lvl;
    cnt_d  = cnt_q;
    if (!active) begin
      cnt_d = '0;
    end else if (edge_hit) begin
      cnt_d = fire ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((decode_sel(mode) == SEL_CAPTURE) && !mode_chg) |-> (cnt_q <= limit));

  p_cnt_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (cnt_q == '0));

endmodule

// File: rtl/ccp_compare.sv
`timescale 1ns/1ps
module ccp_compare
  import ccp_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode,
  input  logic             mode_chg,
  input  logic [TMR_W-1:0] tmr_wide,
  input  logic [TMR_W-1:0] cmp_val,
  output logic             fire,
  output logic             pin_q,
  output logic             evt_q
);

  logic match, hit_q;
  logic pin_d, evt_d;

  assign match = (tmr_wide == cmp_val);
  assign fire  = (decode_sel(mode) == SEL_COMPARE) && !mode_chg && match && !hit_q;

  always_comb begin
    pin_d = pin_q;
    evt_d = fire && (mode == M_CMP_EVT);
    if (mode_chg) begin
      pin_d = (mode == M_CMP_CLR);
    end else if (fire) begin
      if (mode == M_CMP_SET) pin_d = 1'b1;
      else if (mode == M_CMP_CLR) pin_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      pin_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      hit_q <= match;
      pin_q <= pin_d;
      evt_q <= evt_d;
    end
  end

  p_evt_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);

  p_evt_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> ($past(mode) == M_CMP_EVT));

  p_pin_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (mode == M_CMP_SET)) |=> pin_q);

  p_pin_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (mode == M_CMP_CLR)) |=> !pin_q);

endmodule

// File: rtl/ccp_pwm.sv
`timescale 1ns/1ps
module ccp_pwm #(
  parameter int PWM_W = 8,
  parameter int SUB_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [PWM_W+SUB_W-1:0] duty_shadow,
  input  logic [PWM_W-1:0]       tmr_period,
  input  logic [SUB_W-1:0]       tmr_sub,
  input  logic                   period_hit,
  output logic                   pwm_q
);

  localparam int DUTY_W = PWM_W + SUB_W;

  logic [DUTY_W-1:0] duty_act_q, duty_act_d;
  logic [DUTY_W-1:0] count;
  logic              pwm_d;

  assign count = {tmr_period, tmr_sub};

  always_comb begin
    duty_act_d = duty_act_q;
    pwm_d      = pwm_q;
    if (!en) begin
      pwm_d = 1'b0;
    end else if (period_hit) begin
      duty_act_d = duty_shadow;
      pwm_d      = (duty_shadow != '0);
    end else if (pwm_q && (count >= duty_act_q)) begin
      pwm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act_q <= '0;
      pwm_q      <= 1'b0;
    end else begin
      duty_act_q <= duty_act_d;
      pwm_q      <= pwm_d;
    end
  end

  p_zero_duty_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act_q == '0) |-> !pwm_q);

  p_rise_at_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_q) |-> $past(period_hit));

  p_duty_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !period_hit |=> $stable(duty_act_q));

endmodule

// File: rtl/ccp_unit.sv
`timescale 1ns/1ps
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int PWM_W       = 8,
  parameter int SUB_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [TMR_W-1:0] tmr_wide,
  input  logic [PWM_W-1:0] tmr_period,
  input  logic [SUB_W-1:0] tmr_sub,
  input  logic             period_hit,
  input  logic             cap_in,
  output logic             ccp_pin,
  output logic             ccp_flag,
  output logic             ccp_event
);

  localparam int BYTE_W = 8;
  localparam int CTRL_W = 4 + SUB_W;
  localparam logic [1:0] A_VAL_LO = 2'd0;
  localparam logic [1:0] A_VAL_HI = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;
  localparam logic [1:0] A_FLAG   = 2'd3;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [TMR_W-1:0]  val_q, val_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              flag_q, flag_d;
  logic [3:0]        mode_q, mode;
  logic              mode_chg;
  logic              cap_fire, cmp_fire, cmp_pin, pwm_pin;
  ccp_sel_e          sel;

  assign mode     = ctrl_q[3:0];
  assign mode_chg = (mode != mode_q);
  assign sel      = decode_sel(mode);

  ccp_capture #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(EDGE_CNT_W)) u_capture (
    .clk(clk), .rst_n(rst_n_i), .mode(mode), .mode_chg(mode_chg),
    .cap_in(cap_in), .fire(cap_fire)
  );

  ccp_compare #(.TMR_W(TMR_W)) u_compare (
    .clk(clk), .rst_n(rst_n_i), .mode(mode), .mode_chg(mode_chg),
    .tmr_wide(tmr_wide), .cmp_val(val_q), .fire(cmp_fire),
    .pin_q(cmp_pin), .evt_q(ccp_event)
  );

  ccp_pwm #(.PWM_W(PWM_W), .SUB_W(SUB_W)) u_pwm (
    .clk(clk), .rst_n(rst_n_i), .en(sel == SEL_PWM),
    .duty_shadow({val_q[PWM_W-1:0], ctrl_q[CTRL_W-1:4]}),
    .tmr_period(tmr_period), .tmr_sub(tmr_sub), .period_hit(period_hit),
    .pwm_q(pwm_pin)
  );

  always_comb begin
    val_d  = val_q;
    ctrl_d = ctrl_q;
    flag_d = flag_q;
    if (reg_we) begin
      case (reg_addr)
        A_VAL_LO: val_d[BYTE_W-1:0]      = reg_wdata;
        A_VAL_HI: val_d[TMR_W-1:BYTE_W]  = reg_wdata;
        A_CTRL:   ctrl_d                 = reg_wdata[CTRL_W-1:0];
        default:  flag_d                 = reg_wdata[0];
      endcase
    end
    if (cap_fire) val_d = tmr_wide;
    if (cap_fire || cmp_fire) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      val_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
      mode_q <= '0;
    end else begin
      val_q  <= val_d;
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      mode_q <= mode;
    end
  end

  always_comb begin
    case (reg_addr)
      A_VAL_LO: reg_rdata = val_q[BYTE_W-1:0];
      A_VAL_HI: reg_rdata = val_q[TMR_W-1:BYTE_W];
      A_CTRL:   reg_rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
      default:  reg_rdata = {{(BYTE_W-1){1'b0}}, flag_q};
    endcase
  end

  always_comb begin
    case (sel)
      SEL_COMPARE: ccp_pin = cmp_pin;
      SEL_PWM:     ccp_pin = pwm_pin;
      default:     ccp_pin = 1'b0;
    endcase
  end

  assign ccp_flag = flag_q;

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (flag_q && !(reg_we && (reg_addr == A_FLAG) && !reg_wdata[0])) |=> flag_q);

  p_cap_latch_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    cap_fire |=> (val_q == $past(tmr_wide)));

  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sel == SEL_OFF) |-> (!cap_fire && !cmp_fire));

  p_one_source_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(cap_fire && cmp_fire));

endmodule

// File: tb/ccp_unit_tb.sv
`timescale 1ns/1ps
module ccp_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] tmr_wide;
  logic [7:0]  tmr_period;
  logic [1:0]  tmr_sub;
  logic        period_hit;
  logic        cap_in;
  logic        ccp_pin, ccp_flag, ccp_event;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ccp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_wide(tmr_wide),
    .tmr_period(tmr_period), .tmr_sub(tmr_sub), .period_hit(period_hit),
    .cap_in(cap_in), .ccp_pin(ccp_pin), .ccp_flag(ccp_flag),
    .ccp_event(ccp_event)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_mode(input logic [7:0] c);
    wr(2'd2, c);
    idle(2);
  endtask

  task automatic pin_to(input logic v);
    @(negedge clk);
    cap_in = v;
    idle(4);
  endtask

  task automatic rise_edge();
    pin_to(1'b1);
    pin_to(1'b0);
  endtask

  task automatic read_val(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic pulse_period();
    @(negedge clk);
    tmr_period = 8'd0; tmr_sub = 2'd0; period_hit = 1'b1;
    @(negedge clk);
    period_hit = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 register reset", {8'h0, d}, 16'h0);
    end
    chk("R1 pin reset", {15'h0, ccp_pin}, 16'h0);
    chk("R1 flag reset", {15'h0, ccp_flag}, 16'h0);
    chk("R1 event reset", {15'h0, ccp_event}, 16'h0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'hFF);
    rd(2'd0, d); chk("R12 value low", {8'h0, d}, 16'h00A5);
    rd(2'd1, d); chk("R12 value high", {8'h0, d}, 16'h003C);
    rd(2'd2, d); chk("R12 control bits 7:6 read zero", {8'h0, d}, 16'h003F);
    set_mode(8'h00);
  endtask

  task automatic t_off();
    logic [15:0] v;
    logic [7:0] d;
    set_mode(8'h03);
    wr(2'd0, 8'h11); wr(2'd1, 8'h11);
    tmr_wide = 16'h2222;
    rise_edge();
    rise_edge();
    tmr_wide = 16'h1111;
    idle(3);
    read_val(v);
    chk("R2 off mode value kept", v, 16'h1111);
    chk("R2 off mode flag low", {15'h0, ccp_flag}, 16'h0);
    chk("R2 off mode pin low", {15'h0, ccp_pin}, 16'h0);
    rd(2'd3, d);
    chk("R2 off mode flag register", {8'h0, d}, 16'h0);
    tmr_wide = 16'h0000;
  endtask

  task automatic t_capture_edges();
    logic [15:0] v;
    set_mode(8'h05);
    tmr_wide = 16'hBEEF;
    pin_to(1'b1);
    read_val(v);
    chk("R3 rising capture value", v, 16'hBEEF);
    chk("R3 rising capture flag", {15'h0, ccp_flag}, 16'h1);
    wr(2'd3, 8'h00);
    tmr_wide = 16'h0102;
    pin_to(1'b0);
    read_val(v);
    chk("R3 falling edge ignored in rise mode", v, 16'hBEEF);
    chk("R3 flag stays clear on ignored edge", {15'h0, ccp_flag}, 16'h0);
    set_mode(8'h04);
    tmr_wide = 16'h0304;
    pin_to(1'b1);
    read_val(v);
    chk("R3 rising edge ignored in fall mode", v, 16'hBEEF);
    pin_to(1'b0);
    read_val(v);
    chk("R3 falling capture value", v, 16'h0304);
    chk("R3 falling capture flag", {15'h0, ccp_flag}, 16'h1);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    set_mode(8'h06);
    wr(2'd3, 8'h00);
    for (int i = 0; i < 3; i++) begin
      tmr_wide = 16'h1000 + 16'(i);
      rise_edge();
    end
    chk("R4 no capture before 4th edge", {15'h0, ccp_flag}, 16'h0);
    tmr_wide = 16'h4444;
    rise_edge();
    read_val(v);
    chk("R4 capture on 4th edge", v, 16'h4444);
    chk("R4 flag on 4th edge", {15'h0, ccp_flag}, 16'h1);
    set_mode(8'h07);
    wr(2'd3, 8'h00);
    for (int i = 0; i < 15; i++) begin
      tmr_wide = 16'h2000 + 16'(i);
      rise_edge();
    end
    chk("R4 no capture before 16th edge", {15'h0, ccp_flag}, 16'h0);
    tmr_wide = 16'h1616;
    rise_edge();
    read_val(v);
    chk("R4 capture on 16th edge", v, 16'h1616);
    chk("R4 flag on 16th edge", {15'h0, ccp_flag}, 16'h1);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_restart();
    logic [15:0] v;
    set_mode(8'h07);
    wr(2'd3, 8'h00);
    for (int i = 0; i < 3; i++) rise_edge();
    set_mode(8'h06);
    tmr_wide = 16'h5151;
    rise_edge();
    chk("R5 count restarts after mode change", {15'h0, ccp_flag}, 16'h0);
    for (int i = 0; i < 2; i++) rise_edge();
    chk("R5 still counting at 3rd edge", {15'h0, ccp_flag}, 16'h0);
    tmr_wide = 16'h5252;
    rise_edge();
    read_val(v);
    chk("R5 capture at 4th fresh edge", v, 16'h5252);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_compare_pin();
    tmr_wide = 16'h0000;
    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    set_mode(8'h08);
    chk("R6 set mode starts low", {15'h0, ccp_pin}, 16'h0);
    tmr_wide = 16'h1234;
    idle(1);
    chk("R6 set mode pin high on match", {15'h0, ccp_pin}, 16'h1);
    chk("R6 set mode flag", {15'h0, ccp_flag}, 16'h1);
    wr(2'd3, 8'h00);
    tmr_wide = 16'h0000;
    set_mode(8'h09);
    chk("R6 clear mode starts high", {15'h0, ccp_pin}, 16'h1);
    tmr_wide = 16'h1234;
    idle(1);
    chk("R6 clear mode pin low on match", {15'h0, ccp_pin}, 16'h0);
    chk("R6 clear mode flag", {15'h0, ccp_flag}, 16'h1);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_compare_irq();
    tmr_wide = 16'h0000;
    set_mode(8'h0A);
    tmr_wide = 16'h1234;
    idle(2);
    chk("R7 flag on match", {15'h0, ccp_flag}, 16'h1);
    chk("R7 pin stays low", {15'h0, ccp_pin}, 16'h0);
    chk("R7 no event", {15'h0, ccp_event}, 16'h0);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_compare_event();
    tmr_wide = 16'h0000;
    set_mode(8'h0B);
    @(negedge clk);
    tmr_wide = 16'h1234;
    @(negedge clk);
    chk("R8 event high after match", {15'h0, ccp_event}, 16'h1);
    @(negedge clk);
    chk("R8 event lasts one cycle", {15'h0, ccp_event}, 16'h0);
    idle(3);
    chk("R8 no repeat while timer holds", {15'h0, ccp_event}, 16'h0);
    chk("R8 flag on event", {15'h0, ccp_flag}, 16'h1);
  endtask

  task automatic t_flag();
    wr(2'd0, 8'h77);
    wr(2'd2, 8'h0B);
    idle(5);
    chk("R9 flag survives other writes", {15'h0, ccp_flag}, 16'h1);
    wr(2'd3, 8'h00);
    idle(1);
    chk("R9 flag cleared by writing zero", {15'h0, ccp_flag}, 16'h0);
    tmr_wide = 16'h0000;
    set_mode(8'h00);
  endtask

  task automatic t_pwm();
    tmr_period = 8'd0; tmr_sub = 2'd0;
    wr(2'd0, 8'h40);
    set_mode(8'h2C);
    chk("R10 low before first period", {15'h0, ccp_pin}, 16'h0);
    pulse_period();
    chk("R10 high at period match", {15'h0, ccp_pin}, 16'h1);
    @(negedge clk); tmr_period = 8'h40; tmr_sub = 2'd1;
    idle(2);
    chk("R10 high below duty", {15'h0, ccp_pin}, 16'h1);
    tmr_sub = 2'd2;
    idle(1);
    chk("R10 low at duty", {15'h0, ccp_pin}, 16'h0);
  endtask

  task automatic t_pwm_buffer();
    pulse_period();
    chk("R11 high for old duty", {15'h0, ccp_pin}, 16'h1);
    wr(2'd0, 8'h10);
    @(negedge clk); tmr_period = 8'h20; tmr_sub = 2'd0;
    idle(2);
    chk("R11 mid-period write ignored", {15'h0, ccp_pin}, 16'h1);
    pulse_period();
    @(negedge clk); tmr_period = 8'h10; tmr_sub = 2'd1;
    idle(2);
    chk("R11 new duty not yet reached", {15'h0, ccp_pin}, 16'h1);
    tmr_sub = 2'd2;
    idle(1);
    chk("R11 new duty applied", {15'h0, ccp_pin}, 16'h0);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h0C);
    pulse_period();
    idle(2);
    chk("R10 zero duty stays low", {15'h0, ccp_pin}, 16'h0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    tmr_wide = 16'h0; tmr_period = 8'h0; tmr_sub = 2'd0;
    period_hit = 1'b0; cap_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_regs();
    t_off();
    t_capture_edges();
    t_prescale();
    t_restart();
    t_compare_pin();
    t_compare_irq();
    t_compare_event();
    t_flag();
    t_pwm();
    t_pwm_buffer();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule